// File: doc/BRIEF.md
# Weighted Trace Line Victim Selector

This block picks the way to overwrite when a new trace is written into one set of a trace cache. It does not track recency. Each way holds a few small fields: the number of basic blocks in the trace, whether the trace is non-contiguous, how many of its branch-prediction counters are at zero, and a saturating count of recent hits. The selector adds these up into a score. The valid way with the lowest score is the one to evict.

The surrounding cache reports each hit and each fill, giving the way index. A fill also carries the new line's descriptors. A free-running cycle counter ends a hit window whenever it reaches the programmed window length. At that point every hit count drops to zero, so old popularity fades away. The chosen victim is registered and offered on every cycle.

Top module: `trc_wsel_top`

## Requirements
- R1: After reset every way is invalid, all hit counts are zero, the window counter is zero and `victimWay` is 0.
- R2: When any way is invalid, the victim is the lowest-numbered invalid way, whatever the scores of the valid ways.
- R3: A valid way's score is the sum of four terms: its block count (0..3), 1 if its non-contiguous flag is 0 (else 0), 3 minus its zero-prediction count (0..3), and its hit count (0..3). When all ways are valid, the victim is the way with the smallest score.
- R4: When several valid ways share the smallest score, the lowest-numbered of them is chosen.
- R5: A hit adds one to the hit count of the named way. The count stays at 3 once it is there.
- R6: A fill marks the way valid, stores the three descriptors and sets its hit count to 1. If a hit names the same way in the same cycle, the fill takes effect and the hit does not.
- R7: The window counter rises by one each cycle. In any cycle where it is greater than or equal to `windowSize`, it returns to 0 and every hit count is cleared to 0. A hit in that cycle leaves its way at 1, and a fill in that cycle still sets its way to 1.
- R8: `victimWay` is registered from the state in force before the clock edge. A hit or fill applied at edge k can change the victim at edge k+1 at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hitValid | input | 1 | A lookup hit a way of this set this cycle |
| hitWay | input | 2 | Index of the way that hit |
| fillValid | input | 1 | A new trace is written into this set this cycle |
| fillWay | input | 2 | Index of the way being written |
| fillBlocks | input | 2 | Basic block count of the new trace |
| fillNonContig | input | 1 | 1 when the new trace is non-contiguous |
| fillZeroPred | input | 2 | Number of the new trace's branch-prediction counters at zero |
| windowSize | input | 8 | Length of the hit window in cycles |
| victimWay | output | 2 | Registered index of the way to evict |

## Verification
The hardest case to reach is a window clear that lands in the same cycle as a hit or fill. The cycle counter is not visible at the ports, so the bench cannot simply line stimulus up with it. The bench first sets the window length to zero, which clears on every cycle, and keeps hitting one way. That way should then settle at a count of 1 and tie on score with its neighbours. After that, a random phase with a short window runs against a cycle-exact reference model, so clears happen at many offsets from hits and fills.

// File: rtl/trc_wsel_pkg.sv
`timescale 1ns/1ps
package trc_wsel_pkg;
  localparam int NUM_WAYS = 4;
  localparam int BB_W     = 2;
  localparam int ZP_W     = 2;
  localparam int HIT_W    = 2;
  localparam int WIN_W    = 8;
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam int WT_MAX   = ((1 << BB_W) - 1) + 1 + ((1 << ZP_W) - 1) + ((1 << HIT_W) - 1);
  localparam int WT_W     = $clog2(WT_MAX + 1);

  typedef struct packed {
    logic                clearHits;
    logic [NUM_WAYS-1:0] hitSel;
    logic [NUM_WAYS-1:0] fillSel;
  } strobe_t;

  typedef struct packed {
    logic             valid;
    logic [BB_W-1:0]  blocks;
    logic             nonContig;
    logic [ZP_W-1:0]  zeroPred;
    logic [HIT_W-1:0] hits;
  } line_t;
endpackage

// File: rtl/trc_wsel_ctrl.sv
`timescale 1ns/1ps
module trc_wsel_ctrl
  import trc_wsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitValid,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             fillValid,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [WIN_W-1:0] windowSize,
  output strobe_t          strb
);
  logic [WIN_W-1:0] windowCnt;

  always_comb begin
    strb.clearHits = (windowCnt >= windowSize);
    for (int i = 0; i < NUM_WAYS; i++) begin
      strb.fillSel[i] = fillValid && (fillWay == WAY_W'(i));
      strb.hitSel[i]  = hitValid && (hitWay == WAY_W'(i)) && !strb.fillSel[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               windowCnt <= '0;
    else if (strb.clearHits) windowCnt <= '0;
    else                     windowCnt <= windowCnt + 1'b1;
  end

  // R7: window counter restarts after a clear and otherwise advances by one
  a_r7_window_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearHits |=> (windowCnt == '0));
  a_r7_window_advance: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearHits |=> (windowCnt == $past(windowCnt) + 1'b1));
  // R6: a way never receives both a hit and a fill strobe
  a_r6_fill_over_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hitSel & strb.fillSel) == '0);
endmodule

// File: rtl/trc_wsel_dpath.sv
`timescale 1ns/1ps
module trc_wsel_dpath
  import trc_wsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [BB_W-1:0]  fillBlocks,
  input  logic             fillNonContig,
  input  logic [ZP_W-1:0]  fillZeroPred,
  output logic [WAY_W-1:0] victimWay
);
  localparam logic [ZP_W-1:0]  ZP_ALL  = '1;
  localparam logic [HIT_W-1:0] HIT_ALL = '1;

  line_t               lines  [NUM_WAYS];
  logic [WT_W-1:0]     weight [NUM_WAYS];
  logic [NUM_WAYS-1:0] validVec;
  logic [WAY_W-1:0]    pickWay;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lines[g] <= '0;
      end else if (strb.fillSel[g]) begin
        lines[g].valid     <= 1'b1;
        lines[g].blocks    <= fillBlocks;
        lines[g].nonContig <= fillNonContig;
        lines[g].zeroPred  <= fillZeroPred;
        lines[g].hits      <= HIT_W'(1);
      end else if (strb.clearHits) begin
        lines[g].hits <= strb.hitSel[g] ? HIT_W'(1) : '0;
      end else if (strb.hitSel[g] && lines[g].hits != HIT_ALL) begin
        lines[g].hits <= lines[g].hits + 1'b1;
      end
    end

    always_comb begin
      validVec[g] = lines[g].valid;
      weight[g]   = WT_W'(lines[g].blocks) + WT_W'(!lines[g].nonContig)
                  + WT_W'(ZP_ALL - lines[g].zeroPred) + WT_W'(lines[g].hits);
    end

    // R6: a fill leaves the way valid with one hit
    a_r6_fill_init: assert property (@(posedge clk) disable iff (!rstN)
      strb.fillSel[g] |=> (lines[g].valid && lines[g].hits == HIT_W'(1)));
    // R5: a saturated count stays saturated on a further hit
    a_r5_hit_saturate: assert property (@(posedge clk) disable iff (!rstN)
      (strb.hitSel[g] && !strb.clearHits && lines[g].hits == HIT_ALL) |=> (lines[g].hits == HIT_ALL));
    // R5: an unsaturated count rises by one on a hit
    a_r5_hit_step: assert property (@(posedge clk) disable iff (!rstN)
      (strb.hitSel[g] && !strb.clearHits && lines[g].hits != HIT_ALL)
      |=> (lines[g].hits == $past(lines[g].hits) + 1'b1));
    // R7: a window clear without hit or fill empties the count
    a_r7_clear_hits: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clearHits && !strb.hitSel[g] && !strb.fillSel[g]) |=> (lines[g].hits == '0));
  end

  always_comb begin
    logic            found;
    logic [WT_W-1:0] best;
    found   = 1'b0;
    pickWay = '0;
    best    = weight[0];
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!validVec[i] && !found) begin
        pickWay = WAY_W'(i);
        found   = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 1; i < NUM_WAYS; i++) begin
        if (weight[i] < best) begin
          best    = weight[i];
          pickWay = WAY_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) victimWay <= '0;
    else       victimWay <= pickWay;
  end

  // R2: if some way was invalid, the registered victim names an invalid way
  a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rstN)
    (validVec != '1) |=> ((($past(validVec) >> victimWay) & NUM_WAYS'(1)) == '0));
endmodule

// File: rtl/trc_wsel_top.sv
`timescale 1ns/1ps
module trc_wsel_top
  import trc_wsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitValid,
  input  logic [WAY_W-1:0] hitWay,
  input  logic             fillValid,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [BB_W-1:0]  fillBlocks,
  input  logic             fillNonContig,
  input  logic [ZP_W-1:0]  fillZeroPred,
  input  logic [WIN_W-1:0] windowSize,
  output logic [WAY_W-1:0] victimWay
);
  strobe_t strb;

  trc_wsel_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
    .fillValid(fillValid), .fillWay(fillWay), .windowSize(windowSize), .strb(strb)
  );

  trc_wsel_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .fillBlocks(fillBlocks),
    .fillNonContig(fillNonContig), .fillZeroPred(fillZeroPred), .victimWay(victimWay)
  );
endmodule

// File: tb/sim_trc_wsel_top.sv
`timescale 1ns/1ps
module sim_trc_wsel_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hitValid = 1'b0, fillValid = 1'b0, fillNonContig = 1'b0;
  logic [1:0] hitWay = '0, fillWay = '0, fillBlocks = '0, fillZeroPred = '0;
  logic [7:0] windowSize = 8'd255;
  logic [1:0] victimWay;

  int errors = 0, checks = 0, cycles = 0;
  string phase = "R1";
  bit running = 0;

  int mValid[4], mBlk[4], mNc[4], mZp[4], mHit[4];
  int mCnt = 0, expVictim = 0;

  always #2.5 clk = ~clk;

  trc_wsel_top u0 (
    .clk(clk), .rstN(rstN), .hitValid(hitValid), .hitWay(hitWay),
    .fillValid(fillValid), .fillWay(fillWay), .fillBlocks(fillBlocks),
    .fillNonContig(fillNonContig), .fillZeroPred(fillZeroPred),
    .windowSize(windowSize), .victimWay(victimWay)
  );

  function automatic int modelVictim();
    int best, pick;
    for (int i = 0; i < 4; i++) if (mValid[i] == 0) return i;
    best = 100; pick = 0;
    for (int i = 0; i < 4; i++) begin
      int w;
      w = mBlk[i] + (mNc[i] ? 0 : 1) + (3 - mZp[i]) + mHit[i];
      if (w < best) begin best = w; pick = i; end
    end
    return pick;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mValid[i] = 0; mHit[i] = 0; end
      mCnt = 0; expVictim = 0;
    end else begin
      bit clr;
      expVictim = modelVictim();
      clr = (mCnt >= int'(windowSize));
      mCnt = clr ? 0 : (mCnt + 1) % 256;
      for (int i = 0; i < 4; i++) begin
        bit f, h;
        f = fillValid && int'(fillWay) == i;
        h = hitValid && int'(hitWay) == i && !f;
        if (f) begin
          mValid[i] = 1; mBlk[i] = fillBlocks; mNc[i] = fillNonContig;
          mZp[i] = fillZeroPred; mHit[i] = 1;
        end else if (clr) mHit[i] = h ? 1 : 0;
        else if (h && mHit[i] < 3) mHit[i]++;
      end
    end
  end

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: victimWay=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (running && rstN) check(int'(victimWay), expVictim, phase);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(bit hv, int hw, bit fv, int fw, int blk, bit nc, int zp);
    @(negedge clk);
    hitValid = hv; hitWay = 2'(hw); fillValid = fv; fillWay = 2'(fw);
    fillBlocks = 2'(blk); fillNonContig = nc; fillZeroPred = 2'(zp);
  endtask

  task automatic idle(int n);
    repeat (n) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; running = 1;
    idle(2);
    check(int'(victimWay), 0, "R1");
    phase = "R2";
    step(0, 0, 1, 0, 3, 0, 0);                     // way0 score 8
    idle(2);
    check(int'(victimWay), 1, "R2");
    phase = "R4";
    step(0, 0, 1, 1, 1, 1, 3);                     // way1 score 2
    step(0, 0, 1, 2, 2, 0, 1);                     // way2 score 6
    step(0, 0, 1, 3, 1, 1, 3);                     // way3 score 2
    idle(2);
    check(int'(victimWay), 1, "R4");
    phase = "R3";
    step(1, 1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0, 0); // way1 score 4
    idle(2);
    check(int'(victimWay), 3, "R3");
    phase = "R5";
    step(1, 3, 0, 0, 0, 0, 0); step(1, 3, 0, 0, 0, 0, 0); // way3 score 4
    idle(2);
    check(int'(victimWay), 1, "R4");
    step(1, 3, 0, 0, 0, 0, 0);                     // saturated, stays 4
    idle(2);
    check(int'(victimWay), 1, "R5");
    phase = "R6";
    step(1, 3, 1, 3, 1, 1, 3);                     // fill wins: way3 score 2
    idle(2);
    check(int'(victimWay), 3, "R6");
    phase = "R8";
    step(0, 0, 1, 0, 0, 1, 3);                     // way0 score 1
    idle(1);
    check(int'(victimWay), 3, "R8");
    idle(1);
    check(int'(victimWay), 0, "R8");
    phase = "R7";
    windowSize = 8'd0;
    repeat (6) step(1, 0, 0, 0, 0, 0, 0);          // clear every cycle, way0 held at 1
    idle(2);
    check(int'(victimWay), 0, "R7");
    windowSize = 8'd5;
    repeat (400) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 5)       step(1, $urandom_range(0, 3), 0, 0, 0, 0, 0);
      else if (r < 7)  step($urandom_range(0, 1), $urandom_range(0, 3), 1, $urandom_range(0, 3),
                            $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3));
      else             idle(1);
    end
    phase = "R3";
    windowSize = 8'd40;
    repeat (200) begin
      if ($urandom_range(0, 1) == 1) step(1, $urandom_range(0, 3), 0, 0, 0, 0, 0);
      else step(0, 0, 1, $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 1), $urandom_range(0, 3));
    end
    idle(3);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule